// File: doc/BRIEF.md
# Half-Warp Memory Request Coalescer

This block sits between a group of sixteen parallel lanes and a memory port. Each lane offers one load or store address and an active bit, and all lanes share one element width of 1, 2, 4 or 8 bytes. A `start` pulse captures the whole request. The block then emits the fewest aligned memory transactions it can, one at a time over a valid/ready handshake. Each transaction is 32, 64 or 128 bytes long and carries the mask of the lanes it serves.

Each pass picks the lowest-numbered lane that is still waiting. It takes the aligned segment around that lane's address and gathers every other waiting lane whose address falls in that segment. The segment is 32 bytes for byte elements, 64 bytes for halfword elements and 128 bytes for wider ones. If the bytes the lanes actually touch fit inside one aligned half of the segment, the transaction is halved, and it can be halved again. The served lanes are then retired. When no lane is left, `done` pulses for one cycle. Moving the data and routing it back to the lanes are handled elsewhere.

Top module: `coalescer`

## Requirements
- R1: While reset is high, and after it until the first `start`, `txn_valid` and `done` are low.
- R2: Each transaction contains the lowest-numbered lane still pending, so transactions leave in ascending order of that lead lane.
- R3: The grouping segment is 32 bytes when `elem_size` is 0 (1-byte elements), 64 bytes when it is 1 (2-byte), and 128 bytes when it is 2 or 3 (4-byte or 8-byte).
- R4: Every pending lane whose address lies in the lead lane's aligned segment joins that transaction, and every active lane is served exactly once.
- R5: The transaction is the smallest aligned 32-, 64- or 128-byte block inside the segment that covers every byte the member lanes touch.
- R6: `txn_size` is coded 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes (3 never appears), and `txn_base` is aligned to that size.
- R7: A lane whose active bit was low at `start` never appears in any `txn_mask`.
- R8: If no lane is active, `done` is high in the cycle after `start` and no transaction is offered.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base`, `txn_size` and `txn_mask` hold. Exactly one transaction completes per handshake.
- R10: `done` is high for exactly one cycle, the cycle after the final handshake, with `txn_valid` low. A new `start` is accepted afterwards.
- R11: A `start` that arrives while a request is in progress is ignored, and the request in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture a new request (honoured only when idle) |
| lane_addr | input | LANES*AW | Byte address of each lane, lane 0 in the low bits |
| lane_active | input | LANES | Lane takes part in the request |
| elem_size | input | 2 | Element width code: 0=1, 1=2, 2=4, 3=8 bytes |
| txn_ready | input | 1 | Memory side accepts the offered transaction |
| txn_valid | output | 1 | A transaction is offered |
| txn_base | output | AW | Aligned base address of the transaction |
| txn_size | output | 2 | Transaction length code: 0=32, 1=64, 2=128 bytes |
| txn_mask | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse when every active lane has been served |

## Verification
The assertions rely on two properties of the inputs. Each lane address must be a multiple of the element width, so that no element crosses a 32-byte boundary. The memory side may hold `txn_ready` low for any number of cycles. The stimulus meets the first by rounding every generated address down to the element width. It covers the second by driving `txn_ready` either constantly high or randomly low about one cycle in three. It also mixes strided, permuted, broadcast and scattered address patterns with sparse active masks, and once raises `start` while a request is still running.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        TSZ_32  = 2'd0,
        TSZ_64  = 2'd1,
        TSZ_128 = 2'd2
    } txn_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_FIN  = 2'd2
    } coal_state_e;

    // log2 of the grouping segment for an element width code
    function automatic logic [2:0] seg_shift(input logic [1:0] esz);
        case (esz)
            2'd0:    return 3'd5;
            2'd1:    return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    // quarters: which 32-byte quarters of the 128-byte region are touched
    function automatic txn_size_e size_of_quarters(input logic [3:0] q);
        if (q != 4'b0 && (q & (q - 4'd1)) == 4'b0)
            return TSZ_32;
        else if (q[3:2] == 2'b00 || q[1:0] == 2'b00)
            return TSZ_64;
        else
            return TSZ_128;
    endfunction

    function automatic logic [1:0] low_quarter(input logic [3:0] q);
        if (q[0])      return 2'd0;
        else if (q[1]) return 2'd1;
        else if (q[2]) return 2'd2;
        else           return 2'd3;
    endfunction

endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coal_match.sv
module coal_match #(
    parameter int N  = 16,
    parameter int AW = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N*AW-1:0] addr_flat,
    input  logic [N-1:0]    pend,
    input  logic [IW-1:0]   lead,
    input  logic [2:0]      shift,
    output logic [AW-1:0]   lead_addr,
    output logic [N-1:0]    members,
    output logic [3:0]      quarters
);
    logic [AW-1:0] addr [N];
    logic [3:0]    qhit [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign addr[g]    = addr_flat[g*AW +: AW];
        assign members[g] = pend[g] && (((addr[g] ^ lead_addr) >> shift) == '0);
        assign qhit[g]    = members[g] ? (4'b0001 << addr[g][6:5]) : 4'b0000;
    end

    assign lead_addr = addr[lead];

    always_comb begin
        quarters = 4'b0000;
        for (int i = 0; i < N; i++) quarters = quarters | qhit[i];
    end
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink
    import coal_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lead_addr,
    input  logic [3:0]    quarters,
    output logic [AW-1:0] base,
    output txn_size_e     size
);
    always_comb begin
        size      = size_of_quarters(quarters);
        base      = lead_addr;
        base[6:0] = 7'd0;
        case (size)
            TSZ_32:  base[6:5] = low_quarter(quarters);
            TSZ_64:  base[6]   = (quarters[1:0] == 2'b00);
            default: ;
        endcase
    end
endmodule

// File: rtl/coalescer.sv
module coalescer
    import coal_pkg::*;
#(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES-1:0]    lane_active,
    input  logic [1:0]          elem_size,
    input  logic                txn_ready,
    output logic                txn_valid,
    output logic [AW-1:0]       txn_base,
    output logic [1:0]          txn_size,
    output logic [LANES-1:0]    txn_mask,
    output logic                done
);
    localparam int IW = $clog2(LANES);

    coal_state_e         state;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic [1:0]          esz_q;

    logic [IW-1:0]    lead;
    logic [AW-1:0]    lead_addr;
    logic [LANES-1:0] members;
    logic [3:0]       quarters;
    txn_size_e        size_c;
    logic [LANES-1:0] remaining;

    coal_leader #(.N(LANES)) u_leader (
        .req (pend_q),
        .idx (lead)
    );

    coal_match #(.N(LANES), .AW(AW)) u_match (
        .addr_flat (addr_q),
        .pend      (pend_q),
        .lead      (lead),
        .shift     (seg_shift(esz_q)),
        .lead_addr (lead_addr),
        .members   (members),
        .quarters  (quarters)
    );

    coal_shrink #(.AW(AW)) u_shrink (
        .lead_addr (lead_addr),
        .quarters  (quarters),
        .base      (txn_base),
        .size      (size_c)
    );

    assign txn_valid = (state == ST_SEND);
    assign txn_size  = size_c;
    assign txn_mask  = members;
    assign done      = (state == ST_FIN);
    assign remaining = pend_q & ~members;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            pend_q <= '0;
            esz_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= lane_addr;
                        pend_q <= lane_active;
                        esz_q  <= elem_size;
                        state  <= (lane_active == '0) ? ST_FIN : ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (txn_ready) begin
                        pend_q <= remaining;
                        if (remaining == '0) state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             txn_valid,
    input logic             txn_ready,
    input logic [AW-1:0]    txn_base,
    input logic [1:0]       txn_size,
    input logic [LANES-1:0] txn_mask,
    input logic             done,
    input logic [LANES-1:0] pend
);
    logic [AW-1:0]    align_m;
    logic [LANES-1:0] lowest_pend;

    always_comb begin
        case (txn_size)
            2'd0:    align_m = AW'(31);
            2'd1:    align_m = AW'(63);
            default: align_m = AW'(127);
        endcase
    end
    assign lowest_pend = pend & (~pend + 1'b1);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_size) && $stable(txn_mask)); // R9
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> txn_size != 2'd3); // R6
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_base & align_m) == '0); // R6
    AST_MASK_PENDING: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> txn_mask != '0 && (txn_mask & ~pend) == '0); // R7
    AST_LEAD_SERVED: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_mask & lowest_pend) != '0); // R2
    AST_RETIRE_LANES: assert property (@(posedge clk) disable iff (rst)
        txn_valid && txn_ready |=> pend == ($past(pend) & ~$past(txn_mask))); // R4
    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !txn_valid); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
endmodule

bind coalescer coal_checker #(.LANES(LANES), .AW(AW)) u_coal_chk (
    .clk       (clk),
    .rst       (rst),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_size  (txn_size),
    .txn_mask  (txn_mask),
    .done      (done),
    .pend      (pend_q)
);

// File: tb/coalescer_bench.sv
module coalescer_bench;
    localparam int L = 16;

    logic          clk = 1'b0;
    logic          rst, start, txn_ready;
    logic [L*32-1:0] lane_addr;
    logic [L-1:0]  lane_active;
    logic [1:0]    elem_size;
    logic          txn_valid, done;
    logic [31:0]   txn_base;
    logic [1:0]    txn_size;
    logic [L-1:0]  txn_mask;

    always #4 clk = ~clk;

    coalescer #(.LANES(L), .AW(32)) u_coalescer (
        .clk(clk), .rst(rst), .start(start), .lane_addr(lane_addr),
        .lane_active(lane_active), .elem_size(elem_size), .txn_ready(txn_ready),
        .txn_valid(txn_valid), .txn_base(txn_base), .txn_size(txn_size),
        .txn_mask(txn_mask), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] la [L];
    logic [31:0] e_base [L];
    logic [1:0]  e_size [L];
    logic [L-1:0] e_mask [L];
    int e_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Expected transaction list from the requirements (byte-span method)
    task automatic build_expected();
        logic [L-1:0] pend = lane_active;
        longint bytes = longint'(1) << elem_size;
        longint segsz = (elem_size == 2'd0) ? 32 : (elem_size == 2'd1) ? 64 : 128;
        e_n = 0;
        while (pend != '0) begin
            int lead = 0;
            longint seg, lo, hi;
            logic [L-1:0] m = '0;
            for (int i = L - 1; i >= 0; i--) if (pend[i]) lead = i;
            seg = longint'(la[lead]) / segsz;
            lo = 64'h7fffffffffffffff; hi = 0;
            for (int i = 0; i < L; i++) begin
                if (pend[i] && longint'(la[i]) / segsz == seg) begin
                    m[i] = 1'b1;
                    if (longint'(la[i]) < lo) lo = longint'(la[i]);
                    if (longint'(la[i]) + bytes - 1 > hi) hi = longint'(la[i]) + bytes - 1;
                end
            end
            if ((lo >> 5) == (hi >> 5)) begin
                e_size[e_n] = 2'd0; e_base[e_n] = 32'(lo & ~longint'(31));
            end else if ((lo >> 6) == (hi >> 6)) begin
                e_size[e_n] = 2'd1; e_base[e_n] = 32'(lo & ~longint'(63));
            end else begin
                e_size[e_n] = 2'd2; e_base[e_n] = 32'(lo & ~longint'(127));
            end
            e_mask[e_n] = m;
            pend = pend & ~m;
            e_n++;
        end
    endtask

    // rmode 0: ready always high; 1: random stalls
    task automatic run_case(input string tag, input int rmode, input bit inject, output int got);
        int k = 0;
        int guard = 0;
        bit held = 0;
        bit prev_last = 0;
        bit injected = 0;
        logic [31:0] s_base;
        logic [1:0]  s_size;
        logic [L-1:0] s_mask;
        for (int i = 0; i < L; i++) lane_addr[i*32 +: 32] = la[i];
        build_expected();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (e_n == 0) begin
            check(done == 1'b1, "R8", {tag, " done after start"}, done, 1);
            check(txn_valid == 1'b0, "R8", {tag, " no transaction"}, txn_valid, 0);
            got = 0;
            @(negedge clk);
            return;
        end
        forever begin
            bit r;
            start = 1'b0;
            if (done) begin
                check(k == e_n && prev_last, "R10", {tag, " done timing"}, k, e_n);
                check(!txn_valid, "R10", {tag, " valid with done"}, txn_valid, 0);
                break;
            end
            if (held) begin
                check(txn_valid && txn_base == s_base && txn_size == s_size && txn_mask == s_mask,
                      "R9", {tag, " hold while stalled"}, {txn_base, txn_mask}, {s_base, s_mask});
            end
            if (txn_valid && k >= e_n) begin
                check(0, "R4", {tag, " extra transaction"}, k, e_n);
                break;
            end
            r = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
            txn_ready = r;
            prev_last = 0;
            if (txn_valid && r) begin
                check(txn_mask == e_mask[k], "R4", {tag, " mask"}, txn_mask, e_mask[k]);
                check(txn_size == e_size[k], "R5", {tag, " size"}, txn_size, e_size[k]);
                check(txn_base == e_base[k], "R6", {tag, " base"}, txn_base, e_base[k]);
                prev_last = (k == e_n - 1);
                k++;
            end
            held = txn_valid && !r;
            s_base = txn_base; s_size = txn_size; s_mask = txn_mask;
            if (inject && held && !injected) begin
                start = 1'b1;
                lane_active = 16'h0001;
                injected = 1;
            end
            guard++;
            if (guard > 400) begin
                check(0, "R10", {tag, " no done"}, guard, 0);
                break;
            end
            @(negedge clk);
        end
        txn_ready = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R10", {tag, " done one cycle"}, done, 0);
        got = k;
    endtask

    task automatic fill_stride(input logic [31:0] base, input int stride_elems);
        for (int i = 0; i < L; i++)
            la[i] = base + 32'(i * stride_elems) * (32'd1 << elem_size);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R10", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int got;
        void'($urandom(32'd20250611));
        rst = 1'b1; start = 1'b0; txn_ready = 1'b0;
        lane_addr = '0; lane_active = '0; elem_size = 2'd0;
        repeat (3) @(negedge clk);
        check(!txn_valid && !done, "R1", "in reset", {txn_valid, done}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!txn_valid && !done, "R1", "idle after reset", {txn_valid, done}, 0);

        // R3 / R5 directed
        elem_size = 2'd2; lane_active = '1; fill_stride(32'h1000, 1);
        run_case("R3 word unit stride", 0, 0, got);
        fill_stride(32'h1040, 1);
        run_case("R5 word upper half", 0, 0, got);
        elem_size = 2'd0; fill_stride(32'h2000, 1);
        run_case("R3 byte unit stride", 0, 0, got);
        elem_size = 2'd1; fill_stride(32'h2020, 1);
        run_case("R5 half shrink to 32", 1, 0, got);
        elem_size = 2'd3; fill_stride(32'h3000, 1);
        run_case("R3 dword 128 span", 1, 0, got);
        elem_size = 2'd2; fill_stride(32'h4000, 2);
        run_case("R4 word stride two", 1, 0, got);
        fill_stride(32'h5004, 0);
        run_case("R4 broadcast", 0, 0, got);
        for (int i = 0; i < L; i++) la[i] = 32'h8000 + 32'((L - 1 - i) * 128);
        run_case("R2 reversed lanes", 1, 0, got);
        lane_active = 16'h0000;
        run_case("R8 empty", 0, 0, got);
        lane_active = 16'hA5A0; fill_stride(32'h6000, 1);
        run_case("R7 sparse active", 1, 0, got);
        lane_active = 16'h0000;
        run_case("R8 empty again", 0, 0, got);

        // R11: start while busy
        elem_size = 2'd2; lane_active = '1; fill_stride(32'h7000, 8);
        begin
            int want;
            run_case("R11 start while busy", 1, 1, got);
            want = e_n;
            check(got == want, "R11", "transactions after busy start", got, want);
        end

        // random mixes
        for (int t = 0; t < 60; t++) begin
            int pat = $urandom % 4;
            int sel = $urandom % 3;
            logic [31:0] b = 32'($urandom % 65536);
            elem_size = 2'($urandom % 4);
            lane_active = (sel == 0) ? '1 : 16'($urandom);
            for (int i = 0; i < L; i++) begin
                case (pat)
                    0: la[i] = b + 32'(i * (1 << ($urandom % 3))) * (32'd1 << elem_size);
                    1: la[i] = b + 32'($urandom % 512);
                    2: la[i] = b + 32'(((i * 7) % L)) * (32'd1 << elem_size);
                    default: la[i] = 32'($urandom);
                endcase
                la[i] = la[i] & ~((32'd1 << elem_size) - 32'd1);
            end
            run_case("R4 random", t % 2, 0, got);
        end

        summary();
        $finish;
    end
endmodule